// File: doc/BRIEF.md
# Grouped Interrupt Expander

The block gathers a wide set of peripheral interrupt request lines and folds them into a small number of CPU interrupt lines. The request inputs are split into groups, and each group drives one CPU line. Every group has its own flag register, which records rising edges on its sources, and its own enable register, which selects the sources that may raise the group's line. A single acknowledge word holds one bit per group. While a group's bit is set, that group cannot raise its line again.

Software uses a 16-bit word-addressed register bus. When the CPU takes a group interrupt, it presents the group number and receives one cycle later the flat vector index of the winning source. The block clears that source's flag at the same time. The CPU can also present a software trap number. For a trap, the block returns the vector of the first source of that group and does not look at any flag. Any request that has no valid target returns an error pulse instead of a vector.

Top module: `irq_expander`

## Requirements
- R1: When expansion is on, a group's acknowledge bit is clear and at least one of its sources has both its flag and its enable bit set, the group's CPU line pulses high for exactly one cycle. The group's acknowledge bit sets in the same cycle as the pulse.
- R2: Register map, word offsets on a 5-bit bus:
  - 0x00 is control. Bit 0 turns expansion on.
  - 0x01 is acknowledge. Bit g-1 belongs to group g.
  - For group n (1 to 12), the enable register is at 2n and the flag register is at 2n+1.
  - Source n.k is bit k-1 of its group's registers.
  - Unused upper bits read as 0. Enable bits are written directly. Reset clears all registers.
- R3: A flag bit sets on a rising edge of its source input. A source held high does not set the flag again after software clears it.
- R4: Writing 0 to a flag bit clears it. Writing 1 to a flag bit leaves it unchanged.
- R5: While a group's acknowledge bit is set, that group's line stays low. Writing 1 to the bit clears it, and the group can then request again.
- R6: A CPU acknowledge of group g returns, one cycle later and for one cycle, vec_vld_o with index (g-1)*8 + b. Here b is the lowest bit set in flag AND enable for that group. That flag bit clears at the same edge.
- R7: A CPU acknowledge of a group with no pending enabled source, or with a group number outside 1..12, returns a one-cycle vec_err_o pulse and no vector.
- R8: A trap k with k from 1 to 12 returns index (k-1)*8 one cycle later, whatever the flag and enable state.
- R9: A trap 0, or a trap above 12, returns a one-cycle vec_err_o pulse and no vector.
- R10: Source positions marked reserved in the RSV_MASK parameter never set a flag. By default these are bit 2 of group 1, bit 7 of groups 2 to 5, bits 2, 3, 6 and 7 of group 6, bits 6 and 7 of group 9, and all of groups 7, 8, 10, 11 and 12.
- R11: While control bit 0 is 0:
  - all CPU lines stay low;
  - traps and acknowledges give neither a vector nor an error;
  - no flag is cleared by an acknowledge.
- R12: Offsets 0x1A to 0x1F read as 0, and writes to them change no register.
- R13: When an acknowledge and a trap arrive in the same cycle, the acknowledge is served and the trap is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 96 | Peripheral request lines; bit (n-1)*8+k-1 is source n.k |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 5 | Word offset |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational, zero when no access |
| cpu_irq_o | output | 12 | CPU interrupt lines, bit g-1 for group g |
| iack_vld_i | input | 1 | CPU takes a group interrupt |
| iack_grp_i | input | 4 | Group being taken, 1..12 |
| trap_vld_i | input | 1 | Software trap request |
| trap_num_i | input | 4 | Trap number |
| vec_vld_o | output | 1 | Vector index valid, one-cycle pulse |
| vec_idx_o | output | 7 | Flat vector index, 0..95 |
| vec_err_o | output | 1 | Request had no valid target, one-cycle pulse |

## Verification
The in-RTL assertions check these properties on every cycle:
- a CPU line only rises from a clear acknowledge bit while expansion is on;
- a set acknowledge bit stays set until software writes to clear it;
- reserved flags stay zero;
- valid and error never pulse together;
- any returned index lies inside the source range;
- the response path stays silent while expansion is off.

Other behaviour needs the bench's scenarios:
- the lowest-bit winner choice and the flag it clears;
- the exact trap indices;
- edge-only flag setting under a held level;
- re-arming through the acknowledge word;
- reserved-offset reads;
- acknowledge-over-trap priority.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_ACK  = 1;
  localparam int unsigned OFS_GRP  = 2;  // group g (0-based): enable at OFS_GRP+2g, flag at +1

  typedef struct packed {
    logic vld;
    logic err;
  } rsp_kind_t;
endpackage

// File: rtl/irqx_group.sv
module irqx_group #(
  parameter int unsigned NSRC = 8,
  parameter logic [NSRC-1:0] RSV = '0,
  localparam int unsigned SW = $clog2(NSRC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            xp_en_i,
  input  logic [NSRC-1:0] src_i,
  input  logic            en_we_i,
  input  logic            fl_we_i,
  input  logic            ack_clr_i,
  input  logic [NSRC-1:0] wdata_i,
  input  logic            take_i,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] fl_o,
  output logic            ack_o,
  output logic            irq_o,
  output logic            win_vld_o,
  output logic [SW-1:0]   win_bit_o
);
  logic [NSRC-1:0] src_q, fl_q, en_q, hit, rise, fl_keep, take_mask;
  logic            ack_q, irq_q, pend;

  assign rise      = src_i & ~src_q & ~RSV;
  assign hit       = fl_q & en_q;
  assign fl_keep   = fl_we_i ? wdata_i : '1;
  assign take_mask = (take_i && win_vld_o) ? (NSRC'(1) << win_bit_o) : '0;
  assign pend      = xp_en_i && !ack_q && (|hit);

  // lowest set bit wins
  always_comb begin
    win_vld_o = 1'b0;
    win_bit_o = '0;
    for (int i = int'(NSRC) - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win_vld_o = 1'b1;
        win_bit_o = SW'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      fl_q  <= '0;
      en_q  <= '0;
      ack_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      src_q <= src_i;
      fl_q  <= (fl_q & fl_keep & ~take_mask) | rise;  // new edge beats clear
      if (en_we_i) en_q <= wdata_i;
      ack_q <= (ack_q && !ack_clr_i) || pend;
      irq_q <= pend;
    end
  end

  assign en_o  = en_q;
  assign fl_o  = fl_q;
  assign ack_o = ack_q;
  assign irq_o = irq_q;

  a_r1_irq_from_clear_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(ack_o));
  a_r11_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(xp_en_i));
  a_r5_ack_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !ack_clr_i) |=> ack_o);
  a_r10_rsv_never_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_o & RSV) == '0);
endmodule

// File: rtl/irqx_vector.sv
module irqx_vector #(
  parameter int unsigned NGRP = 12,
  parameter int unsigned NSRC = 8,
  localparam int unsigned GW = $clog2(NGRP + 1),
  localparam int unsigned SW = $clog2(NSRC),
  localparam int unsigned VW = $clog2(NGRP * NSRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               xp_en_i,
  input  logic               iack_vld_i,
  input  logic [GW-1:0]      iack_grp_i,
  input  logic               trap_vld_i,
  input  logic [GW-1:0]      trap_num_i,
  input  logic [NGRP-1:0]    win_vld_i,
  input  logic [NGRP*SW-1:0] win_bit_i,
  output logic [NGRP-1:0]    take_o,
  output logic               vec_vld_o,
  output logic [VW-1:0]      vec_idx_o,
  output logic               err_o
);
  import irqx_pkg::*;

  rsp_kind_t   nxt;
  logic [VW-1:0] nxt_idx, ia_idx, tr_idx;
  logic        ia_hit, tr_ok;
  logic [NGRP-1:0] ia_sel;

  always_comb begin
    ia_hit = 1'b0;
    ia_idx = '0;
    ia_sel = '0;
    tr_ok  = 1'b0;
    tr_idx = '0;
    for (int g = 0; g < int'(NGRP); g++) begin
      if (iack_grp_i == GW'(g + 1)) begin
        ia_sel[g] = 1'b1;
        ia_hit    = win_vld_i[g];
        ia_idx    = VW'(g * int'(NSRC)) + VW'(win_bit_i[g*SW +: SW]);
      end
      if (trap_num_i == GW'(g + 1)) begin
        tr_ok  = 1'b1;
        tr_idx = VW'(g * int'(NSRC));
      end
    end
  end

  always_comb begin
    nxt     = '0;
    nxt_idx = '0;
    take_o  = '0;
    if (xp_en_i) begin
      if (iack_vld_i) begin
        nxt.vld = ia_hit;
        nxt.err = !ia_hit;
        nxt_idx = ia_hit ? ia_idx : '0;
        take_o  = ia_sel;
      end else if (trap_vld_i) begin
        nxt.vld = tr_ok;
        nxt.err = !tr_ok;
        nxt_idx = tr_ok ? tr_idx : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_vld_o <= 1'b0;
      err_o     <= 1'b0;
      vec_idx_o <= '0;
    end else begin
      vec_vld_o <= nxt.vld;
      err_o     <= nxt.err;
      vec_idx_o <= nxt_idx;
    end
  end

  a_r9_vld_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vec_vld_o && err_o));
  a_r6_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> (int'(vec_idx_o) < int'(NGRP * NSRC)));
  a_r11_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xp_en_i |=> (!vec_vld_o && !err_o));
  a_r7_grp0_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xp_en_i && iack_vld_i && iack_grp_i == '0) |=> err_o);
endmodule

// File: rtl/irq_expander.sv
module irq_expander #(
  parameter int unsigned NGRP = 12,
  parameter int unsigned NSRC = 8,
  parameter int unsigned DW   = 16,
  parameter int unsigned AW   = 5,
  parameter logic [NGRP*NSRC-1:0] RSV_MASK = 96'hFFFF_FFC0_FFFF_CC80_8080_8004,
  localparam int unsigned GW = $clog2(NGRP + 1),
  localparam int unsigned SW = $clog2(NSRC),
  localparam int unsigned VW = $clog2(NGRP * NSRC)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NGRP*NSRC-1:0] src_i,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic [AW-1:0]        bus_addr_i,
  input  logic [DW-1:0]        bus_wdata_i,
  output logic [DW-1:0]        bus_rdata_o,
  output logic [NGRP-1:0]      cpu_irq_o,
  input  logic                 iack_vld_i,
  input  logic [GW-1:0]        iack_grp_i,
  input  logic                 trap_vld_i,
  input  logic [GW-1:0]        trap_num_i,
  output logic                 vec_vld_o,
  output logic [VW-1:0]        vec_idx_o,
  output logic                 vec_err_o
);
  import irqx_pkg::*;

  logic                 wr, xp_en_q;
  logic [NSRC-1:0]      en_w [NGRP];
  logic [NSRC-1:0]      fl_w [NGRP];
  logic [NGRP-1:0]      ack_w, win_vld, take;
  logic [NGRP*SW-1:0]   win_bit;
  logic                 unused_wdata;

  assign wr           = bus_req_i && bus_we_i;
  assign unused_wdata = ^bus_wdata_i[DW-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     xp_en_q <= 1'b0;
    else if (wr && bus_addr_i == AW'(OFS_CTRL))      xp_en_q <= bus_wdata_i[0];
  end

  for (genvar g = 0; g < int'(NGRP); g++) begin : g_grp
    logic en_we, fl_we, ack_clr;
    assign en_we   = wr && bus_addr_i == AW'(OFS_GRP + 2*g);
    assign fl_we   = wr && bus_addr_i == AW'(OFS_GRP + 2*g + 1);
    assign ack_clr = wr && bus_addr_i == AW'(OFS_ACK) && bus_wdata_i[g];

    irqx_group #(
      .NSRC (NSRC),
      .RSV  (RSV_MASK[g*NSRC +: NSRC])
    ) u_grp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .xp_en_i   (xp_en_q),
      .src_i     (src_i[g*NSRC +: NSRC]),
      .en_we_i   (en_we),
      .fl_we_i   (fl_we),
      .ack_clr_i (ack_clr),
      .wdata_i   (bus_wdata_i[NSRC-1:0]),
      .take_i    (take[g]),
      .en_o      (en_w[g]),
      .fl_o      (fl_w[g]),
      .ack_o     (ack_w[g]),
      .irq_o     (cpu_irq_o[g]),
      .win_vld_o (win_vld[g]),
      .win_bit_o (win_bit[g*SW +: SW])
    );
  end

  irqx_vector #(
    .NGRP (NGRP),
    .NSRC (NSRC)
  ) u_vec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .xp_en_i    (xp_en_q),
    .iack_vld_i (iack_vld_i),
    .iack_grp_i (iack_grp_i),
    .trap_vld_i (trap_vld_i),
    .trap_num_i (trap_num_i),
    .win_vld_i  (win_vld),
    .win_bit_i  (win_bit),
    .take_o     (take),
    .vec_vld_o  (vec_vld_o),
    .vec_idx_o  (vec_idx_o),
    .err_o      (vec_err_o)
  );

  // reserved offsets fall through to zero
  always_comb begin
    bus_rdata_o = '0;
    if (bus_req_i) begin
      if (bus_addr_i == AW'(OFS_CTRL)) bus_rdata_o = DW'(xp_en_q);
      if (bus_addr_i == AW'(OFS_ACK))  bus_rdata_o = DW'(ack_w);
      for (int g = 0; g < int'(NGRP); g++) begin
        if (bus_addr_i == AW'(OFS_GRP + 2*g))     bus_rdata_o = DW'(en_w[g]);
        if (bus_addr_i == AW'(OFS_GRP + 2*g + 1)) bus_rdata_o = DW'(fl_w[g]);
      end
    end
  end
endmodule

// File: tb/tb_irq_expander.sv
`timescale 1ns/1ps
module tb_irq_expander;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [95:0] src_i = '0;
  logic        bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [4:0]  bus_addr_i = '0;
  logic [15:0] bus_wdata_i = '0, bus_rdata_o;
  logic [11:0] cpu_irq_o;
  logic        iack_vld_i = 1'b0, trap_vld_i = 1'b0;
  logic [3:0]  iack_grp_i = '0, trap_num_i = '0;
  logic        vec_vld_o, vec_err_o;
  logic [6:0]  vec_idx_o;

  int n_tests = 0, n_fail = 0;
  int irq_cnt [12];

  always #5 clk_i = ~clk_i;

  irq_expander dut (.*);

  initial for (int g = 0; g < 12; g++) irq_cnt[g] = 0;
  always @(posedge clk_i) begin
    #1;
    for (int g = 0; g < 12; g++) irq_cnt[g] += int'(cpu_irq_o[g]);
  end

  // {trap number, expect valid, expect error, expected index}
  localparam logic [12:0] TRAP_TAB [8] = '{
    {4'd1,  1'b1, 1'b0, 7'd0},
    {4'd2,  1'b1, 1'b0, 7'd8},
    {4'd5,  1'b1, 1'b0, 7'd32},
    {4'd9,  1'b1, 1'b0, 7'd64},
    {4'd12, 1'b1, 1'b0, 7'd88},
    {4'd0,  1'b0, 1'b1, 7'd0},
    {4'd13, 1'b0, 1'b1, 7'd0},
    {4'd15, 1'b0, 1'b1, 7'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = 5'(a); bus_wdata_i = 16'(d);
    @(negedge clk_i);
    bus_req_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = 5'(a);
    #1 d = int'(bus_rdata_o);
    @(negedge clk_i);
    bus_req_i = 1'b0;
  endtask

  task automatic rsp(output int v, output int e, output int x);
    @(negedge clk_i);
    v = int'(vec_vld_o); e = int'(vec_err_o); x = int'(vec_idx_o);
    iack_vld_i = 1'b0; trap_vld_i = 1'b0;
  endtask

  task automatic do_iack(input int g, output int v, output int e, output int x);
    iack_vld_i = 1'b1; iack_grp_i = 4'(g);
    rsp(v, e, x);
  endtask

  task automatic do_trap(input int k, output int v, output int e, output int x);
    trap_vld_i = 1'b1; trap_num_i = 4'(k);
    rsp(v, e, x);
  endtask

  task automatic pulse(input int idx);
    src_i[idx] = 1'b1;
    @(negedge clk_i);
    src_i[idx] = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    int d, v, e, x, c0, c8;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset state
    check("R2 reset irq", int'(cpu_irq_o), 0);
    check("R2 reset vld", int'(vec_vld_o), 0);
    rd(0, d); check("R2 reset ctrl", d, 0);
    rd(1, d); check("R2 reset ack", d, 0);
    rd(3, d); check("R2 reset flag1", d, 0);

    // expansion off
    wr(2, 16'hFF);
    c0 = irq_cnt[0];
    pulse(3);
    check("R11 no irq when off", irq_cnt[0] - c0, 0);
    do_trap(1, v, e, x);
    check("R11 trap silent vld", v, 0); check("R11 trap silent err", e, 0);
    do_iack(1, v, e, x);
    check("R11 iack silent", v + e, 0);
    rd(3, d); check("R3 flag from edge, R11 not taken", d, 16'h0008);

    // turn on: pending flag raises line
    c0 = irq_cnt[0];
    wr(0, 1);
    repeat (3) @(negedge clk_i);
    check("R1 one pulse", irq_cnt[0] - c0, 1);
    rd(1, d); check("R1 ack set", d, 1);

    // trap table
    for (int i = 0; i < 8; i++) begin
      logic [12:0] t;
      t = TRAP_TAB[i];
      do_trap(int'(t[12:9]), v, e, x);
      if (t[8]) begin
        check("R8 trap vld", v, 1); check("R8 trap idx", x, int'(t[6:0]));
      end else begin
        check("R9 trap err", e, 1); check("R9 trap no vld", v, 0);
      end
    end

    // reserved position and second source
    c0 = irq_cnt[0];
    pulse(2);
    rd(3, d); check("R10 reserved flag stays 0", d, 16'h0008);
    pulse(5);
    rd(3, d); check("R3 second flag", d, 16'h0028);
    check("R5 blocked while acked", irq_cnt[0] - c0, 0);
    do_trap(1, v, e, x);
    check("R8 trap ignores flags", x, 0);

    do_iack(1, v, e, x);
    check("R6 winner vld", v, 1); check("R6 winner idx", x, 3);
    rd(3, d); check("R6 flag auto clear", d, 16'h0020);
    iack_vld_i = 1'b1; iack_grp_i = 4'd1; trap_vld_i = 1'b1; trap_num_i = 4'd2;
    rsp(v, e, x);
    check("R13 iack wins", x, 5);
    rd(3, d); check("R13 flag cleared", d, 0);
    do_iack(1, v, e, x); check("R7 empty group err", e, 1);
    do_iack(0, v, e, x); check("R7 group0 err", e, 1);
    do_iack(13, v, e, x); check("R7 group13 err", e, 1);

    // re-arm through ack
    c0 = irq_cnt[0];
    pulse(4);
    check("R5 still blocked", irq_cnt[0] - c0, 0);
    wr(1, 1);
    repeat (3) @(negedge clk_i);
    check("R5 rearmed pulse", irq_cnt[0] - c0, 1);
    rd(1, d); check("R5 ack set again", d, 1);

    // software flag clear
    rd(3, d); check("R4 flag before", d, 16'h0010);
    wr(3, 16'hFFFF); rd(3, d); check("R4 write 1 no effect", d, 16'h0010);
    wr(3, 16'hFFEF); rd(3, d); check("R4 write 0 clears", d, 0);

    // held level
    src_i[6] = 1'b1;
    repeat (3) @(negedge clk_i);
    rd(3, d); check("R3 level sets once", d, 16'h0040);
    wr(3, 0);
    repeat (3) @(negedge clk_i);
    rd(3, d); check("R3 held level no reset", d, 0);
    src_i[6] = 1'b0;

    // reserved offsets, map
    wr(26, 16'hFFFF); rd(26, d); check("R12 reserved read 0", d, 0);
    rd(31, d); check("R12 top offset 0", d, 0);
    rd(0, d); check("R12 ctrl untouched", d, 1);
    rd(2, d); check("R12 enable untouched", d, 16'h00FF);
    wr(4, 16'hFF01); rd(4, d); check("R2 upper bits zero", d, 16'h0001);

    // group 9
    c8 = irq_cnt[8];
    wr(18, 16'h0020);
    pulse(69);
    check("R1 group9 pulse", irq_cnt[8] - c8, 1);
    do_iack(9, v, e, x);
    check("R6 group9 idx", x, 69);

    // off again
    wr(0, 0); wr(1, 16'h0FFF);
    c0 = irq_cnt[0];
    pulse(0);
    repeat (2) @(negedge clk_i);
    check("R11 off no irq", irq_cnt[0] - c0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule